// File: doc/BRIEF.md
# H-Bridge Input Mode Controller

This block converts two logic-level control inputs into per-half-bridge commands for a full-bridge motor output. Each half-bridge command is one of three states: high impedance, drive high, or drive low. Analog gate drivers downstream act on these commands. Dead-time insertion, current sensing and the serial transport that fills the register-side inputs are handled elsewhere.

Two control schemes are supported. The first is phase/enable, where one input gates the bridge and the other selects the direction. The second is two-input PWM, where each input drives one direction. A 2-bit mode code picks the scheme. The parameter `REG_CTRL` selects where that code comes from:

- With `REG_CTRL = 0`, the code is sampled from a pin once, at the end of the initialization window that follows reset or a wake from sleep.
- With `REG_CTRL = 1`, the code is a register field that is used live. In this variant the sleep pin is ignored, and a register override may replace the two input pins.

A driver-off input and sleep both force every output to high impedance. A current-trip event that arrives while the bridge is sourcing current pulls any high-driven output low for a fixed number of cycles.

Top module: `hbridge_mode_ctrl`

## Requirements
- R1: While reset is asserted, both outputs are high impedance (code 2'b00). After reset is released, they stay high impedance until the initialization window of INIT_CYCLES+1 clocks has completed.
- R2: When drvOff is 1, both outputs become high impedance at the next clock. This takes priority over every other input.
- R3: With REG_CTRL=0, sleepN=0 makes both outputs high impedance at the next clock. With REG_CTRL=1, sleepN has no effect.
- R4: Mode 2'b00 is phase/enable, with in1 as the enable and in2 as the phase. Enable 0 drives both outputs low. Enable 1 with phase 1 drives out1 high and out2 low; phase 0 does the reverse. Output codes are: 2'b00 high impedance, 2'b01 drive high, 2'b10 drive low. Outputs follow the inputs one clock later.
- R5: Mode 2'b11 is PWM, keyed on {in1,in2}. The value 00 gives both outputs high impedance. 10 gives out1 high and out2 low, 01 gives the reverse, and 11 drives both outputs low.
- R6: Mode codes 2'b01 and 2'b10 give both outputs high impedance.
- R7: With REG_CTRL=0, modePin is captured only at the end of initialization. Changes to it during operation have no effect until the next wake.
- R8: With REG_CTRL=1, a change of regMode takes effect at the next clock, with no re-initialization.
- R9: With REG_CTRL=1 and regPinOvr=1, regIn1 and regIn2 replace in1 and in2. With REG_CTRL=0, the override inputs have no effect.
- R10: Suppose tripEn=1 and tripHit=1 while an output would be driven high. Then, starting one clock after that edge, every high-driven output is driven low for TRIP_HOLD clocks, after which normal control resumes. With tripEn=0, tripHit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| sleepN | input | 1 | Active-low sleep (REG_CTRL=0 only) |
| drvOff | input | 1 | Forces both outputs to high impedance |
| in1 | input | 1 | Control input 1 (enable or forward PWM) |
| in2 | input | 1 | Control input 2 (phase or reverse PWM) |
| modePin | input | 2 | Mode code from pin, latched at initialization |
| regMode | input | 2 | Mode code from register, used live |
| regPinOvr | input | 1 | Register override enable for the control inputs |
| regIn1 | input | 1 | Override value for in1 |
| regIn2 | input | 1 | Override value for in2 |
| tripEn | input | 1 | Current-trip regulation enable |
| tripHit | input | 1 | Current-trip level reached |
| out1State | output | 2 | Half-bridge 1 command |
| out2State | output | 2 | Half-bridge 2 command |

## Verification
The bench runs both variants side by side on shared stimulus, so a sleep event shows up as high impedance on one instance and has no effect on the other. It changes the mode pin after latching and feeds the PWM pattern 0/1, whose expected result differs between phase/enable and PWM. A design that samples the pin live would brake instead of driving reverse. The trip window is counted edge by edge: a counter that is off by one would release the low drive a clock early or late, and one that ignores the enable would clamp while tripEn is 0. Reserved codes are applied both live and latched, and a decoder that falls back to a scheme would drive the outputs instead of releasing them.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    HS_HIZ  = 2'b00,
    HS_HIGH = 2'b01,
    HS_LOW  = 2'b10
  } halfState_e;

  typedef enum logic [1:0] {
    MODE_PHEN = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_PWM  = 2'b11
  } ctrlMode_e;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'b00,
    ST_INIT   = 2'b01,
    ST_ACTIVE = 2'b10
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic bridgeEn;   // outputs may drive
    logic modeLoad;   // capture pin mode this cycle
    logic tripForce;  // trip hold window active
  } dpStrobe_t;

  typedef struct packed {
    halfState_e out1;
    halfState_e out2;
  } bridgeCmd_t;

  function automatic bridgeCmd_t decodeCmd(logic [1:0] mode, logic a, logic b);
    bridgeCmd_t c;
    c.out1 = HS_HIZ;
    c.out2 = HS_HIZ;
    case (mode)
      MODE_PHEN: begin
        if (!a) begin
          c.out1 = HS_LOW;
          c.out2 = HS_LOW;
        end else if (b) begin
          c.out1 = HS_HIGH;
          c.out2 = HS_LOW;
        end else begin
          c.out1 = HS_LOW;
          c.out2 = HS_HIGH;
        end
      end
      MODE_PWM: begin
        case ({a, b})
          2'b10: begin c.out1 = HS_HIGH; c.out2 = HS_LOW;  end
          2'b01: begin c.out1 = HS_LOW;  c.out2 = HS_HIGH; end
          2'b11: begin c.out1 = HS_LOW;  c.out2 = HS_LOW;  end
          default: begin c.out1 = HS_HIZ; c.out2 = HS_HIZ; end
        endcase
      end
      default: begin
        c.out1 = HS_HIZ;
        c.out2 = HS_HIZ;
      end
    endcase
    return c;
  endfunction

  function automatic halfState_e clampLow(halfState_e s);
    return (s == HS_HIGH) ? HS_LOW : s;
  endfunction

endpackage

// File: rtl/hbm_ctrl.sv
module hbm_ctrl
  import hbm_pkg::*;
#(
  parameter int INIT_CYCLES = 4,
  parameter int TRIP_HOLD   = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepEff,
  input  logic      tripEn,
  input  logic      tripHit,
  input  logic      sourcing,
  output dpStrobe_t strobe
);

  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int HOLD_W = $clog2(TRIP_HOLD + 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(TRIP_HOLD);

  ctrlState_e        state, stateNext;
  logic [INIT_W-1:0] initCnt, initCntNext;
  logic [HOLD_W-1:0] holdCnt;
  logic              initDone;
  logic              tripStart;

  assign initDone = (state == ST_INIT) && (initCnt == '0);

  always_comb begin
    stateNext   = state;
    initCntNext = initCnt;
    if (!sleepEff) begin
      stateNext   = ST_SLEEP;
      initCntNext = '0;
    end else begin
      case (state)
        ST_SLEEP: begin
          stateNext   = ST_INIT;
          initCntNext = INIT_LAST;
        end
        ST_INIT: begin
          if (initDone) stateNext = ST_ACTIVE;
          else          initCntNext = initCnt - 1'b1;
        end
        default: stateNext = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SLEEP;
      initCnt <= '0;
    end else begin
      state   <= stateNext;
      initCnt <= initCntNext;
    end
  end

  assign tripStart = (state == ST_ACTIVE) && sleepEff && tripEn && tripHit &&
                     sourcing && (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (tripStart)      holdCnt <= HOLD_LOAD;
    else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
  end

  assign strobe.bridgeEn  = (state == ST_ACTIVE) && sleepEff;
  assign strobe.modeLoad  = initDone && sleepEff;
  assign strobe.tripForce = (holdCnt != '0);

endmodule

// File: rtl/hbm_datapath.sv
module hbm_datapath
  import hbm_pkg::*;
#(
  parameter int REG_CTRL = 0,
  parameter int LANES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       drvOff,
  input  logic       in1,
  input  logic       in2,
  input  logic [1:0] modePin,
  input  logic [1:0] regMode,
  input  logic       regPinOvr,
  input  logic       regIn1,
  input  logic       regIn2,
  output logic       sourcing,
  output logic [1:0] out1State,
  output logic [1:0] out2State
);

  localparam bit LIVE_MODE = (REG_CTRL != 0);

  logic [1:0] modeQ;
  logic [1:0] modeSel;
  logic       inA, inB;
  bridgeCmd_t baseCmd;
  halfState_e laneNext [LANES];
  halfState_e laneQ    [LANES];

  // Pin mode latch, loaded once per initialization
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                modeQ <= MODE_PHEN;
    else if (strobe.modeLoad) modeQ <= modePin;
  end

  assign modeSel = LIVE_MODE ? regMode : modeQ;
  assign inA     = (LIVE_MODE && regPinOvr) ? regIn1 : in1;
  assign inB     = (LIVE_MODE && regPinOvr) ? regIn2 : in2;

  assign baseCmd  = decodeCmd(modeSel, inA, inB);
  assign sourcing = strobe.bridgeEn && !drvOff &&
                    ((baseCmd.out1 == HS_HIGH) || (baseCmd.out2 == HS_HIGH));

  always_comb begin
    laneNext[0] = baseCmd.out1;
    laneNext[1] = baseCmd.out2;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    halfState_e gated;
    always_comb begin
      if (!strobe.bridgeEn || drvOff) gated = HS_HIZ;
      else if (strobe.tripForce)      gated = clampLow(laneNext[g]);
      else                            gated = laneNext[g];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ[g] <= HS_HIZ;
      else       laneQ[g] <= gated;
    end
  end

  assign out1State = laneQ[0];
  assign out2State = laneQ[1];

endmodule

// File: rtl/hbridge_mode_ctrl.sv
module hbridge_mode_ctrl
  import hbm_pkg::*;
#(
  parameter int REG_CTRL    = 0,
  parameter int INIT_CYCLES = 4,
  parameter int TRIP_HOLD   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepN,
  input  logic       drvOff,
  input  logic       in1,
  input  logic       in2,
  input  logic [1:0] modePin,
  input  logic [1:0] regMode,
  input  logic       regPinOvr,
  input  logic       regIn1,
  input  logic       regIn2,
  input  logic       tripEn,
  input  logic       tripHit,
  output logic [1:0] out1State,
  output logic [1:0] out2State
);

  dpStrobe_t strobe;
  logic      sourcing;
  logic      sleepEff;

  // Register-configured variant has no sleep input: always awake
  assign sleepEff = (REG_CTRL != 0) ? 1'b1 : sleepN;

  hbm_ctrl #(
    .INIT_CYCLES(INIT_CYCLES),
    .TRIP_HOLD  (TRIP_HOLD)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sleepEff(sleepEff),
    .tripEn  (tripEn),
    .tripHit (tripHit),
    .sourcing(sourcing),
    .strobe  (strobe)
  );

  hbm_datapath #(
    .REG_CTRL(REG_CTRL),
    .LANES   (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .drvOff   (drvOff),
    .in1      (in1),
    .in2      (in2),
    .modePin  (modePin),
    .regMode  (regMode),
    .regPinOvr(regPinOvr),
    .regIn1   (regIn1),
    .regIn2   (regIn2),
    .sourcing (sourcing),
    .out1State(out1State),
    .out2State(out2State)
  );

endmodule

// File: rtl/hbm_checker.sv
module hbm_checker #(
  parameter int REG_CTRL = 0
) (
  input logic       clk,
  input logic       rstN,
  input logic       sleepN,
  input logic       drvOff,
  input logic [1:0] regMode,
  input logic [1:0] out1State,
  input logic [1:0] out2State
);

  // R1: held reset keeps the bridge released
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      p_reset_hiz_r1: assert (out1State == 2'b00 && out2State == 2'b00)
        else $error("reset output not high impedance");
    end
  end

  p_drvoff_hiz_r2: assert property (@(posedge clk) disable iff (!rstN)
    drvOff |=> (out1State == 2'b00 && out2State == 2'b00));

  p_sleep_hiz_r3: assert property (@(posedge clk) disable iff (!rstN)
    (REG_CTRL == 0 && !sleepN) |=> (out1State == 2'b00 && out2State == 2'b00));

  // R4: no shoot-through request and no illegal code
  p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(out1State == 2'b01 && out2State == 2'b01) &&
    out1State != 2'b11 && out2State != 2'b11);

  p_reserved_hiz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (REG_CTRL != 0 && (regMode == 2'b01 || regMode == 2'b10))
      |=> (out1State == 2'b00 && out2State == 2'b00));

endmodule

bind hbridge_mode_ctrl hbm_checker #(.REG_CTRL(REG_CTRL)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .sleepN   (sleepN),
  .drvOff   (drvOff),
  .regMode  (regMode),
  .out1State(out1State),
  .out2State(out2State)
);

// File: tb/test_hbridge_mode_ctrl.sv
`timescale 1ns/1ps
module test_hbridge_mode_ctrl;

  localparam int HOLD = 8;
  localparam int INIT = 4;
  localparam logic [1:0] HZ = 2'b00, HI = 2'b01, LO = 2'b10;

  logic clk = 1'b0;
  logic rstN, sleepN, drvOff, in1, in2, regPinOvr, regIn1, regIn2, tripEn, tripHit;
  logic [1:0] modePin, regMode;
  logic [1:0] pOut1, pOut2, rOut1, rOut2;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbridge_mode_ctrl #(.REG_CTRL(0), .INIT_CYCLES(INIT), .TRIP_HOLD(HOLD)) i_hbridge_mode_ctrl (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .drvOff(drvOff), .in1(in1), .in2(in2),
    .modePin(modePin), .regMode(regMode), .regPinOvr(regPinOvr), .regIn1(regIn1),
    .regIn2(regIn2), .tripEn(tripEn), .tripHit(tripHit),
    .out1State(pOut1), .out2State(pOut2));

  hbridge_mode_ctrl #(.REG_CTRL(1), .INIT_CYCLES(INIT), .TRIP_HOLD(HOLD)) i_hbridge_mode_ctrl_reg (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .drvOff(drvOff), .in1(in1), .in2(in2),
    .modePin(modePin), .regMode(regMode), .regPinOvr(regPinOvr), .regIn1(regIn1),
    .regIn2(regIn2), .tripEn(tripEn), .tripHit(tripHit),
    .out1State(rOut1), .out2State(rOut2));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] a1, input logic [1:0] a2,
                     input logic [1:0] e1, input logic [1:0] e2);
    checks++;
    if (a1 !== e1 || a2 !== e2) begin
      errors++;
      $display("FAIL %s act=%b/%b exp=%b/%b", tag, a1, a2, e1, e2);
    end
  endtask

  task automatic t_reset;
    rstN = 0; sleepN = 1; drvOff = 0; in1 = 1; in2 = 1; modePin = 2'b00;
    regMode = 2'b00; regPinOvr = 0; regIn1 = 0; regIn2 = 0; tripEn = 0; tripHit = 0;
    step(3);
    chk("R1 pin in reset", pOut1, pOut2, HZ, HZ);
    chk("R1 reg in reset", rOut1, rOut2, HZ, HZ);
    rstN = 1;
    step(2);
    chk("R1 pin during init", pOut1, pOut2, HZ, HZ);
    chk("R1 reg during init", rOut1, rOut2, HZ, HZ);
    step(8);
    chk("R4 pin en1 ph1", pOut1, pOut2, HI, LO);
    chk("R4 reg en1 ph1", rOut1, rOut2, HI, LO);
  endtask

  task automatic t_phen;
    in1 = 1; in2 = 0; step(1);
    chk("R4 pin en1 ph0", pOut1, pOut2, LO, HI);
    in1 = 0; step(1);
    chk("R4 pin en0 brake", pOut1, pOut2, LO, LO);
    chk("R4 reg en0 brake", rOut1, rOut2, LO, LO);
  endtask

  task automatic t_drvoff;
    in1 = 1; in2 = 1; drvOff = 1; step(1);
    chk("R2 pin drvOff", pOut1, pOut2, HZ, HZ);
    chk("R2 reg drvOff", rOut1, rOut2, HZ, HZ);
    drvOff = 0; step(1);
    chk("R2 pin release", pOut1, pOut2, HI, LO);
  endtask

  task automatic t_regmode;
    regMode = 2'b11; in1 = 0; in2 = 0; step(1);
    chk("R8 R5 reg pwm coast", rOut1, rOut2, HZ, HZ);
    chk("R8 pin ignores regMode", pOut1, pOut2, LO, LO);
    in1 = 1; step(1);
    chk("R5 reg pwm fwd", rOut1, rOut2, HI, LO);
    in1 = 0; in2 = 1; step(1);
    chk("R5 reg pwm rev", rOut1, rOut2, LO, HI);
    in1 = 1; step(1);
    chk("R5 reg pwm brake", rOut1, rOut2, LO, LO);
    regMode = 2'b01; step(1);
    chk("R6 reg code 01", rOut1, rOut2, HZ, HZ);
    regMode = 2'b10; step(1);
    chk("R6 reg code 10", rOut1, rOut2, HZ, HZ);
    regMode = 2'b00; step(1);
    chk("R8 reg back to phen", rOut1, rOut2, HI, LO);
  endtask

  task automatic t_override;
    in1 = 0; in2 = 0; regIn1 = 1; regIn2 = 0; regPinOvr = 1; step(1);
    chk("R9 reg override", rOut1, rOut2, LO, HI);
    chk("R9 pin ignores override", pOut1, pOut2, LO, LO);
    regPinOvr = 0; step(1);
    chk("R9 reg override off", rOut1, rOut2, LO, LO);
  endtask

  task automatic t_sleep;
    in1 = 1; in2 = 1; sleepN = 0; step(1);
    chk("R3 pin sleep", pOut1, pOut2, HZ, HZ);
    chk("R3 reg ignores sleep", rOut1, rOut2, HI, LO);
    modePin = 2'b11; step(2);
    sleepN = 1; step(8);
    chk("R7 pin latched pwm brake", pOut1, pOut2, LO, LO);
    modePin = 2'b00; in1 = 0; in2 = 1; step(2);
    chk("R7 pin change ignored", pOut1, pOut2, LO, HI);
    sleepN = 0; modePin = 2'b10; step(2);
    sleepN = 1; in1 = 1; in2 = 0; step(8);
    chk("R6 pin latched reserved", pOut1, pOut2, HZ, HZ);
    sleepN = 0; modePin = 2'b00; step(2);
    sleepN = 1; in1 = 1; in2 = 1; step(8);
    chk("R7 pin relatched phen", pOut1, pOut2, HI, LO);
  endtask

  task automatic t_trip;
    in1 = 1; in2 = 1; tripEn = 0; tripHit = 1; step(3);
    chk("R10 trip disabled", pOut1, pOut2, HI, LO);
    tripEn = 1; step(1);
    tripHit = 0;
    chk("R10 edge of trip", pOut1, pOut2, HI, LO);
    step(1);
    chk("R10 hold start", pOut1, pOut2, LO, LO);
    step(HOLD - 1);
    chk("R10 hold end", pOut1, pOut2, LO, LO);
    step(1);
    chk("R10 resume", pOut1, pOut2, HI, LO);
    tripEn = 0;
  endtask

  initial begin
    t_reset();
    t_phen();
    t_drvoff();
    t_regmode();
    t_override();
    t_sleep();
    t_trip();
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule